// File: doc/BRIEF.md
# Perspective Projection Matrix Generator

This block turns three view angles into a 4x4 fixed-point transform that a downstream vertex unit applies to model points. It takes an azimuth, an elevation and a field-of-view angle. It forms a rotation from the first two, a translation that follows the view direction, and a perspective stage whose strength comes from the field of view. It then multiplies them as perspective times translation times rotation.

A one-cycle `start_i` samples the three angles and launches the computation. Sine and cosine values come from a quarter-wave table that is built when the design is elaborated. The field-of-view term is a tangent, formed by a bit-serial restoring divide. All products go through a single rounding, saturating multiplier that a step sequencer shares. When the sixteen coefficients are ready they are loaded into the output register and `done_o` pulses for one cycle. A start that arrives while a run is in progress is dropped.

Top module: `proj_matrix_gen`

## Requirements
- R1: Angles are unsigned `ANG_W`-bit values, with 2^ANG_W counts making one full turn. Every sine and cosine is taken from a quarter-wave table whose entry k equals round(2^FRAC_W * sin(k * 2pi / 2^ANG_W)), and quadrant symmetry extends it to the full turn.
- R2: Each coefficient is a signed Q(COEF_W-FRAC_W).FRAC_W value. Coefficient (row r, column c) sits in `coef_o[(4r+c)*COEF_W +: COEF_W]`. Row 0 is all zero.
- R3: With tz = -azimuth and tx = elevation - quarter turn: (1,0) = cos(tx)sin(tz), (1,1) = cos(tx)cos(tz), (1,2) = -sin(tx), (2,0) = sin(tx)sin(tz), (2,1) = sin(tx)cos(tz), (2,2) = cos(tx). Each is within 16 LSB of the ideal value.
- R4: The translation column is (1,3) = 1/2 - (sqrt(3)/2)cos(el)cos(az) and (2,3) = 1/2 + (sqrt(3)/2)sin(el), each within 16 LSB.
- R5: Row 3 is w times row 1 plus 1 at (3,3). Here w = tan(h) is the reciprocal focal distance and h = floor(fov/2) in angle counts. Each entry is within 16 LSB of the ideal value saturated to the coefficient range.
- R6: A field of view of zero gives an exactly orthogonal result, with row 3 equal to 0, 0, 0, 2^FRAC_W.
- R7: When cos(h) is zero, w saturates to the largest positive coefficient. Every product and sum clamps to the signed COEF_W range instead of wrapping.
- R8: `done_o` is high for exactly one cycle per run. `coef_o` changes only in the cycle in which `done_o` is high, and otherwise holds its value.
- R9: A `start_i` seen while a run is in progress has no effect. It produces no extra `done_o`, and the result reflects the angles sampled by the accepted start.
- R10: While `rst_ni` is low, `done_o` is 0 and `coef_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, sampled only when idle |
| azim_i | input | ANG_W | Azimuth angle |
| elev_i | input | ANG_W | Elevation angle |
| fov_i | input | ANG_W | Viewing (field-of-view) angle |
| done_o | output | 1 | One-cycle pulse marking new coefficients |
| coef_o | output | 16*COEF_W | Sixteen coefficients, row-major, element 0 in the low bits |

## Verification
The bench builds the block with its defaults: 10-bit angles and 16-bit coefficients with 12 fraction bits. With these values every quadrant boundary of the table is reachable with a single angle count. A field of view of 512 drives cos(h) to exactly zero, which forces the divider into saturation, and an opposed azimuth at zero elevation pushes (3,3) past the top of the range. Random angles with a fixed seed cover the general case, and the field of view is kept below 341 so that the tangent stays well conditioned against the 16 LSB tolerance.

// File: rtl/proj_pkg.sv
package proj_pkg;

  parameter int ANG_W  = 10;
  parameter int COEF_W = 16;
  parameter int FRAC_W = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_TRIG, ST_RUN, ST_OUT} seq_st_e;

  // integer square root, bit by bit
  function automatic longint isqrt(longint v);
    longint r;
    longint t;
    r = 0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (longint'(1) <<< b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

endpackage

// File: rtl/proj_sin_lut.sv
module proj_sin_lut #(
  parameter int ANG_W  = proj_pkg::ANG_W,
  parameter int COEF_W = proj_pkg::COEF_W,
  parameter int FRAC_W = proj_pkg::FRAC_W
) (
  input  logic        [ANG_W-1:0]  ang_i,
  output logic signed [COEF_W-1:0] sin_o
);
  localparam int QW = ANG_W - 2;
  localparam int QN = 1 << QW;

  // quarter wave in Q30 via Taylor series, rounded to FRAC_W
  function automatic logic [QN:0][FRAC_W:0] build_tab();
    logic [QN:0][FRAC_W:0] t;
    longint x, x2, term, acc;
    for (int k = 0; k <= QN; k++) begin
      x    = (longint'(1686629713) * longint'(k)) / longint'(QN);
      x2   = (x * x) >>> 30;
      term = x;
      acc  = x;
      for (int n = 1; n < 10; n++) begin
        term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
        acc  = acc + term;
      end
      acc = (acc + (longint'(1) <<< (29 - FRAC_W))) >>> (30 - FRAC_W);
      if (acc > (longint'(1) <<< FRAC_W)) acc = longint'(1) <<< FRAC_W;
      if (acc < 0) acc = 0;
      t[k] = acc[FRAC_W:0];
    end
    return t;
  endfunction

  localparam logic [QN:0][FRAC_W:0] TAB = build_tab();

  logic [1:0]      quad;
  logic [QW:0]     idx, mir;
  logic [FRAC_W:0] mag;

  always_comb begin
    quad  = ang_i[ANG_W-1:ANG_W-2];
    idx   = {1'b0, ang_i[QW-1:0]};
    mir   = (QW+1)'(QN) - idx;
    mag   = quad[0] ? TAB[mir] : TAB[idx];
    sin_o = quad[1] ? -$signed(COEF_W'(mag)) : $signed(COEF_W'(mag));
  end

endmodule

// File: rtl/proj_div.sv
module proj_div #(
  parameter int COEF_W = proj_pkg::COEF_W,
  parameter int FRAC_W = proj_pkg::FRAC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [COEF_W-1:0] num_i,
  input  logic signed [COEF_W-1:0] den_i,
  output logic                     done_o,
  output logic signed [COEF_W-1:0] quo_o
);
  localparam int DW = COEF_W + FRAC_W;
  localparam int CW = $clog2(DW + 1);
  localparam logic signed [COEF_W-1:0] MAXV = {1'b0, {(COEF_W-1){1'b1}}};

  logic [DW-1:0]       dvd_q, quo_q;
  logic [COEF_W-1:0]   rem_q, dsr_q;
  logic [CW-1:0]       cnt_q;
  logic                neg_q, busy_q, done_q;
  logic signed [COEF_W-1:0] num_q;
  logic [COEF_W-1:0]   num_abs, den_abs;
  logic [COEF_W:0]     rem_sh;
  logic                fits;
  logic [COEF_W-1:0]   sat;

  always_comb begin
    num_abs = num_i[COEF_W-1] ? COEF_W'(-num_i) : COEF_W'(num_i);
    den_abs = den_i[COEF_W-1] ? COEF_W'(-den_i) : COEF_W'(den_i);
    rem_sh  = {rem_q, dvd_q[DW-1]};
    fits    = rem_sh >= {1'b0, dsr_q};
    sat     = (|quo_q[DW-1:COEF_W-1]) ? COEF_W'(MAXV) : quo_q[COEF_W-1:0];
    quo_o   = neg_q ? -$signed(sat) : $signed(sat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      num_q  <= '0;
    end else if (start_i && !busy_q) begin
      dvd_q  <= {num_abs, {FRAC_W{1'b0}}};
      quo_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= den_abs;
      cnt_q  <= CW'(DW);
      neg_q  <= num_i[COEF_W-1] ^ den_i[COEF_W-1];
      busy_q <= 1'b1;
      done_q <= 1'b0;
      num_q  <= num_i;
    end else if (busy_q) begin
      dvd_q  <= dvd_q << 1;
      quo_q  <= {quo_q[DW-2:0], fits};
      rem_q  <= fits ? COEF_W'(rem_sh - {1'b0, dsr_q}) : rem_sh[COEF_W-1:0];
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CW'(1));
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;

  // R7: zero divisor must land on the clamp
  a_r7_div_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dsr_q == '0) |-> (quo_o == MAXV || quo_o == -MAXV));

  // R6: zero numerator gives an exact zero quotient
  a_r6_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && num_q == '0) |-> (quo_o == '0));

endmodule

// File: rtl/proj_mrs.sv
module proj_mrs #(
  parameter int COEF_W = proj_pkg::COEF_W,
  parameter int FRAC_W = proj_pkg::FRAC_W
) (
  input  logic signed [COEF_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] b_i,
  input  logic signed [COEF_W-1:0] c_i,
  output logic signed [COEF_W-1:0] y_o
);
  localparam int PW = 2 * COEF_W + 1;
  localparam logic signed [PW-1:0] MAXP = PW'((64'sd1 <<< (COEF_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINP = -MAXP - PW'(1);
  localparam logic signed [PW-1:0] RND  = PW'(64'sd1 <<< (FRAC_W - 1));

  logic signed [PW-1:0] prod, rnd, sum;

  always_comb begin
    prod = PW'(a_i) * PW'(b_i);
    rnd  = (prod + RND) >>> FRAC_W;
    sum  = rnd + PW'(c_i);
    if (sum > MAXP)      y_o = MAXP[COEF_W-1:0];
    else if (sum < MINP) y_o = MINP[COEF_W-1:0];
    else                 y_o = sum[COEF_W-1:0];
  end

endmodule

// File: rtl/proj_matrix_gen.sv
module proj_matrix_gen #(
  parameter int ANG_W  = proj_pkg::ANG_W,
  parameter int COEF_W = proj_pkg::COEF_W,
  parameter int FRAC_W = proj_pkg::FRAC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ANG_W-1:0]     azim_i,
  input  logic [ANG_W-1:0]     elev_i,
  input  logic [ANG_W-1:0]     fov_i,
  output logic                 done_o,
  output logic [16*COEF_W-1:0] coef_o
);
  localparam int NT    = 9;
  localparam int NS    = 11;
  localparam int SW    = $clog2(NS);
  localparam int N_PRE = 7;   // steps not needing w
  localparam logic [ANG_W-1:0] QTR = ANG_W'(1 << (ANG_W - 2));
  localparam logic signed [COEF_W-1:0] ONE  = COEF_W'(1 << FRAC_W);
  localparam logic signed [COEF_W-1:0] HALF = COEF_W'(1 << (FRAC_W - 1));
  localparam int K = int'((proj_pkg::isqrt(longint'(3) <<< (2 * FRAC_W + 2)) + 2) >>> 2);
  localparam logic signed [COEF_W-1:0] SQ3H  = COEF_W'(K);
  localparam logic signed [COEF_W-1:0] NSQ3H = COEF_W'(-K);

  proj_pkg::seq_st_e state_q;
  logic [ANG_W-1:0]  az_q, el_q, fov_q;
  logic [SW-1:0]     step_q;
  logic              w_ok_q, done_q;
  logic [15:0][COEF_W-1:0] coef_q, coef_d;

  logic [NT-1:0][ANG_W-1:0]  ang_v;
  logic signed [COEF_W-1:0]  lut_v [NT];
  logic signed [COEF_W-1:0]  tv_q  [NT];
  logic signed [COEF_W-1:0]  res_q [NS];
  logic signed [COEF_W-1:0]  op_a, op_b, op_c, mul_y, w_val, nsx;
  logic                      div_start, div_done, step_go;
  logic [ANG_W-1:0]          th_z, th_x, ph;

  // angle set: tz, tz+q, tx, tx+q, el, el+q, az+q, h, h+q
  always_comb begin
    th_z     = -az_q;
    th_x     = el_q - QTR;
    ph       = fov_q >> 1;
    ang_v[0] = th_z;
    ang_v[1] = th_z + QTR;
    ang_v[2] = th_x;
    ang_v[3] = th_x + QTR;
    ang_v[4] = el_q;
    ang_v[5] = el_q + QTR;
    ang_v[6] = az_q + QTR;
    ang_v[7] = ph;
    ang_v[8] = ph + QTR;
  end

  for (genvar g = 0; g < NT; g++) begin : g_lut
    proj_sin_lut #(.ANG_W(ANG_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_lut (
      .ang_i (ang_v[g]),
      .sin_o (lut_v[g])
    );
  end

  assign div_start = (state_q == proj_pkg::ST_TRIG);

  proj_div #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (lut_v[7]),
    .den_i   (lut_v[8]),
    .done_o  (div_done),
    .quo_o   (w_val)
  );

  assign nsx = -tv_q[2];

  // operand schedule: tv 0=sz 1=cz 2=sx 3=cx 4=se 5=ce 6=ca
  always_comb begin
    op_a = '0;
    op_b = '0;
    op_c = '0;
    case (step_q)
      SW'(0):  begin op_a = tv_q[3]; op_b = tv_q[0]; end
      SW'(1):  begin op_a = tv_q[3]; op_b = tv_q[1]; end
      SW'(2):  begin op_a = tv_q[2]; op_b = tv_q[0]; end
      SW'(3):  begin op_a = tv_q[2]; op_b = tv_q[1]; end
      SW'(4):  begin op_a = tv_q[5]; op_b = tv_q[6]; end
      SW'(5):  begin op_a = NSQ3H;   op_b = res_q[4]; op_c = HALF; end
      SW'(6):  begin op_a = SQ3H;    op_b = tv_q[4];  op_c = HALF; end
      SW'(7):  begin op_a = w_val;   op_b = res_q[0]; end
      SW'(8):  begin op_a = w_val;   op_b = res_q[1]; end
      SW'(9):  begin op_a = w_val;   op_b = nsx;      end
      SW'(10): begin op_a = w_val;   op_b = res_q[5]; op_c = ONE; end
      default: ;
    endcase
  end

  proj_mrs #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mrs (
    .a_i (op_a),
    .b_i (op_b),
    .c_i (op_c),
    .y_o (mul_y)
  );

  assign step_go = (step_q < SW'(N_PRE)) || w_ok_q || div_done;

  always_comb begin
    coef_d     = '0;
    coef_d[4]  = res_q[0];
    coef_d[5]  = res_q[1];
    coef_d[6]  = nsx;
    coef_d[7]  = res_q[5];
    coef_d[8]  = res_q[2];
    coef_d[9]  = res_q[3];
    coef_d[10] = tv_q[3];
    coef_d[11] = res_q[6];
    coef_d[12] = res_q[7];
    coef_d[13] = res_q[8];
    coef_d[14] = res_q[9];
    coef_d[15] = res_q[10];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= proj_pkg::ST_IDLE;
      az_q    <= '0;
      el_q    <= '0;
      fov_q   <= '0;
      step_q  <= '0;
      w_ok_q  <= 1'b0;
      done_q  <= 1'b0;
      coef_q  <= '0;
      for (int i = 0; i < NT; i++) tv_q[i]  <= '0;
      for (int i = 0; i < NS; i++) res_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        proj_pkg::ST_IDLE: if (start_i) begin
          az_q    <= azim_i;
          el_q    <= elev_i;
          fov_q   <= fov_i;
          state_q <= proj_pkg::ST_TRIG;
        end
        proj_pkg::ST_TRIG: begin
          for (int i = 0; i < NT; i++) tv_q[i] <= lut_v[i];
          step_q  <= '0;
          w_ok_q  <= 1'b0;
          state_q <= proj_pkg::ST_RUN;
        end
        proj_pkg::ST_RUN: begin
          if (div_done) w_ok_q <= 1'b1;
          if (step_go) begin
            res_q[step_q] <= mul_y;
            if (step_q == SW'(NS - 1)) state_q <= proj_pkg::ST_OUT;
            else                       step_q  <= step_q + 1'b1;
          end
        end
        default: begin
          coef_q  <= coef_d;
          done_q  <= 1'b1;
          state_q <= proj_pkg::ST_IDLE;
        end
      endcase
    end
  end

  assign done_o = done_q;
  assign coef_o = coef_q;

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_coef_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(coef_o));

  a_r9_angles_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != proj_pkg::ST_IDLE) |=> ($stable(az_q) && $stable(el_q) && $stable(fov_q)));

  a_r6_ortho_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fov_q == '0) |->
      (coef_q[12] == '0 && coef_q[13] == '0 && coef_q[14] == '0 && coef_q[15] == ONE));

endmodule

// File: tb/proj_matrix_gen_tb.sv
`timescale 1ns/1ps
module proj_matrix_gen_tb;
  localparam int AW  = 10;
  localparam int CW  = 16;
  localparam int FW  = 12;
  localparam int TOL = 16;
  localparam real PI   = 3.14159265358979323846;
  localparam real QMAX = 32767.0;
  localparam real QMIN = -32768.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] az = '0, el = '0, fov = '0;
  logic done;
  logic [16*CW-1:0] coef;

  int  n_chk = 0;
  int  n_err = 0;
  real exp_m [16];
  int  saved [16];

  always #4 clk = ~clk;

  proj_matrix_gen #(.ANG_W(AW), .COEF_W(CW), .FRAC_W(FW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .azim_i (az), .elev_i (el), .fov_i (fov),
    .done_o (done), .coef_o (coef)
  );

  function automatic int coef_at(int m);
    logic signed [CW-1:0] v;
    v = coef[m*CW +: CW];
    return int'(v);
  endfunction

  function automatic real clampq(real v);
    real s;
    s = v * 4096.0;
    if (s > QMAX) s = QMAX;
    if (s < QMIN) s = QMIN;
    return s;
  endfunction

  task automatic chk(string tag, int act, int expv, int tol);
    int d;
    n_chk++;
    d = act - expv;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (tol %0d)", tag, act, expv, tol);
    end
  endtask

  // ideal matrix from the requirement formulas
  task automatic calc(int a, int e, int f);
    real u, tz, tx, re, ra, h, sz, cz, sx, cx, w, vy, vz, ch;
    u  = 2.0 * PI / 1024.0;
    tz = -a * u;
    tx = (e - 256) * u;
    re = e * u;
    ra = a * u;
    h  = (f / 2) * u;
    sz = $sin(tz); cz = $cos(tz); sx = $sin(tx); cx = $cos(tx);
    ch = $cos(h);
    if (ch < 1e-9 && ch > -1e-9) w = ($sin(h) >= 0.0) ? QMAX / 4096.0 : -QMAX / 4096.0;
    else w = $sin(h) / ch;
    if (w > QMAX / 4096.0) w = QMAX / 4096.0;
    if (w < -QMAX / 4096.0) w = -QMAX / 4096.0;
    vy = 0.5 - $sqrt(3.0) / 2.0 * $cos(re) * $cos(ra);
    vz = 0.5 + $sqrt(3.0) / 2.0 * $sin(re);
    for (int m = 0; m < 4; m++) exp_m[m] = 0.0;
    exp_m[4]  = clampq(cx * sz);
    exp_m[5]  = clampq(cx * cz);
    exp_m[6]  = clampq(-sx);
    exp_m[7]  = clampq(vy);
    exp_m[8]  = clampq(sx * sz);
    exp_m[9]  = clampq(sx * cz);
    exp_m[10] = clampq(cx);
    exp_m[11] = clampq(vz);
    exp_m[12] = clampq(w * cx * sz);
    exp_m[13] = clampq(w * cx * cz);
    exp_m[14] = clampq(w * -sx);
    exp_m[15] = clampq(w * vy + 1.0);
  endtask

  task automatic check_all(string over);
    string tag;
    for (int m = 0; m < 16; m++) begin
      if (over != "")               tag = over;
      else if (m < 4)               tag = "R2";
      else if (m >= 12)             tag = "R5";
      else if (m == 7 || m == 11)   tag = "R4";
      else                          tag = "R3";
      chk($sformatf("%s coef[%0d]", tag, m), coef_at(m), int'(exp_m[m]), (m < 4) ? 0 : TOL);
    end
  endtask

  task automatic pulse_start(int a, int e, int f);
    @(negedge clk);
    az = AW'(a); el = AW'(e); fov = AW'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int cyc;
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    chk($sformatf("%s done seen", tag), int'(done), 1, 0);
    @(negedge clk);
    chk("R8 done lasts one cycle", int'(done), 0, 0);
  endtask

  task automatic run(int a, int e, int f, string over);
    calc(a, e, f);
    pulse_start(a, e, f);
    wait_done("R8");
    check_all(over);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed, ndone, ra, re, rf;
    seed = $urandom(32'h1d2c3b4a);

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 done in reset", int'(done), 0, 0);
    chk("R10 coef in reset", int'(coef == '0), 1, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: orthogonal case, exact row 3
    run(0, 0, 0, "");
    chk("R6 coef[12]", coef_at(12), 0, 0);
    chk("R6 coef[13]", coef_at(13), 0, 0);
    chk("R6 coef[14]", coef_at(14), 0, 0);
    chk("R6 coef[15]", coef_at(15), 4096, 0);
    run(300, 700, 0, "R6");

    // R1: quadrant edges of the table
    run(256, 512, 100, "R1");
    run(768, 256, 300, "R1");
    run(512, 768, 2, "R1");
    run(1023, 1, 255, "R1");

    // R7: cos(h)=0 saturation, (3,3) clamps
    run(512, 0, 512, "R7");
    chk("R7 coef[15] clamp", coef_at(15), 32767, 0);
    run(0, 256, 512, "R7");

    // R8: hold without start
    for (int m = 0; m < 16; m++) saved[m] = coef_at(m);
    @(negedge clk);
    az = 10'd77; el = 10'd900; fov = 10'd33;
    ndone = 0;
    repeat (60) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R8 no done without start", ndone, 0, 0);
    for (int m = 0; m < 16; m++) chk($sformatf("R8 hold coef[%0d]", m), coef_at(m), saved[m], 0);

    // R9: second start while busy is dropped
    calc(140, 333, 120);
    pulse_start(140, 333, 120);
    pulse_start(600, 50, 300);
    wait_done("R9");
    ndone = 0;
    repeat (80) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R9 no extra done", ndone, 0, 0);
    check_all("R9");

    // random angles, moderate field of view
    for (int i = 0; i < 24; i++) begin
      ra = $urandom_range(1023, 0);
      re = $urandom_range(1023, 0);
      rf = $urandom_range(340, 0);
      run(ra, re, rf, "");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule